// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block keeps flag state for an integer pipeline in a deferred form. A flag-setting operation does not produce N, Z, C and V when it retires. It leaves a record of itself instead: a 4-bit operation code and three 64-bit operand words. The record sits in a single register. The flags are rebuilt from that record by combinational logic only when a consumer reads them. This saves the flag computation for the many results whose flags are overwritten before anyone reads them.

The block has two read outputs, and both are purely combinational. The first is a 64-bit status word with the flag nibble placed in bits 31:28. The second answers a condition query. The query is one 8-bit selector: the condition code sits in the upper nibble and an operation code in the lower nibble. The query takes its operation from the selector, so a consumer can read a condition under any operation interpretation of the stored operands.

The write side uses valid/ready. The block never back-pressures: `rec_ready` is always 1, and a record is captured on every clock edge at which `rec_valid` is high. A newer record replaces the older one completely. The read side has no handshake.

Top module: `lazy_flag_unit`

## Requirements
- R1: A record (`rec_op`, `rec_a`, `rec_b`, `rec_c`) is captured at the rising edge where `rec_valid` is 1. It is visible on `flag_word` from that edge. `rec_ready` is always 1.
- R2: After reset the stored record is operation 0 (copy) with all operands zero, so `flag_word` reads 0.
- R3: Operation 0 (copy) returns bits 31:28 of `rec_a` unchanged as N,Z,C,V.
- R4: Operations 1 (32-bit add) and 2 (64-bit add) give the flags of `a + b`. C is the unsigned carry out and V is signed overflow.
- R5: Operations 3 (32-bit sub) and 4 (64-bit sub) give the flags of `a - b`. C is 1 when no borrow occurs, i.e. when a >= b unsigned.
- R6: Operations 5/6 (add with carry, 32/64) use `c[0]` as carry in. Operations 7/8 (subtract with carry, 32/64) compute `a + ~b + c[0]`.
- R7: Operations 9 (32-bit logic) and 10 (64-bit logic) take `a` as the result. N is the top bit of `a` and Z is 1 when `a` is zero, both at the operation width. C and V are 0.
- R8: 32-bit forms (codes 1,3,5,7,9) ignore operand bits 63:32. N, carry and overflow are taken at bit 31/32.
- R9: `flag_word` holds N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. All other bits are 0.
- R10: Query condition codes (selector bits 7:4) are evaluated as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R11: Condition codes 14 and 15 are always true.
- R12: The query result is in bit 0 of `cond_word`, and bits 63:1 are 0. The flags come from the stored operands under the operation code in selector bits 3:0, not the stored code.
- R13: Operation codes 11 to 15 give all-zero flags.
- R14: While `rec_valid` is 0 the stored record, and so `flag_word`, does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record write request |
| rec_ready | output | 1 | Record accept, constant 1 |
| rec_op | input | 4 | Operation code of the record |
| rec_a | input | 64 | First operand word |
| rec_b | input | 64 | Second operand word |
| rec_c | input | 64 | Third operand word (carry in at bit 0) |
| query_sel | input | 8 | Condition code in 7:4, operation code in 3:0 |
| flag_word | output | 64 | Flags of stored record in bits 31:28 |
| cond_word | output | 64 | Query result in bit 0 |

## Verification
Both outputs depend only on the stored record and on `query_sel` through combinational logic. `flag_word` therefore changes at the single rising edge that captures a record. `cond_word` follows a new `query_sel` within the same cycle. Each scenario task drives its inputs at the falling edge and waits for the next rising edge. It samples at the following falling edge, half a period after capture. The bench's expected flags come from signed and unsigned range arithmetic, not from the adder form used in the design.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  localparam logic [3:0] OP_COPY  = 4'd0;
  localparam logic [3:0] OP_ADD_W = 4'd1;
  localparam logic [3:0] OP_ADD_D = 4'd2;
  localparam logic [3:0] OP_SUB_W = 4'd3;
  localparam logic [3:0] OP_SUB_D = 4'd4;
  localparam logic [3:0] OP_ADC_W = 4'd5;
  localparam logic [3:0] OP_ADC_D = 4'd6;
  localparam logic [3:0] OP_SBC_W = 4'd7;
  localparam logic [3:0] OP_SBC_D = 4'd8;
  localparam logic [3:0] OP_LOG_W = 4'd9;
  localparam logic [3:0] OP_LOG_D = 4'd10;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic cond_hit(input logic [3:0] cc, input nzcv_t f);
    logic base;
    case (cc[3:1])
      3'd0: base = f.z;
      3'd1: base = f.c;
      3'd2: base = f.n;
      3'd3: base = f.v;
      3'd4: base = f.c & ~f.z;
      3'd5: base = (f.n == f.v);
      3'd6: base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    if (cc[3:1] == 3'd7) return 1'b1;
    return cc[0] ? ~base : base;
  endfunction

endpackage

// File: rtl/lfu_thunk_reg.sv
module lfu_thunk_reg #(
  parameter int DW = 64,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [OPW-1:0] op_in,
  input  logic [DW-1:0]  a_in,
  input  logic [DW-1:0]  b_in,
  input  logic [DW-1:0]  c_in,
  output logic [OPW-1:0] op_q,
  output logic [DW-1:0]  a_q,
  output logic [DW-1:0]  b_q,
  output logic [DW-1:0]  c_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
    end else if (load) begin
      op_q <= op_in;
      a_q  <= a_in;
      b_q  <= b_in;
      c_q  <= c_in;
    end
  end
endmodule

// File: rtl/lfu_flag_calc.sv
module lfu_flag_calc
  import lfu_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 32,
  parameter int NZCV_LSB = 28
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output nzcv_t         flags
);
  localparam int NWIDTH = 2;

  for (genvar g = 0; g < NWIDTH; g++) begin : g_w
    localparam int W = (g == 0) ? HW : DW;
    logic [W-1:0] x, yy;
    logic [W:0]   s;
    logic         ci, inv;
    nzcv_t        arith, logic_f;
    always_comb begin
      x   = a[W-1:0];
      inv = (op == OP_SUB_W) || (op == OP_SUB_D) || (op == OP_SBC_W) || (op == OP_SBC_D);
      yy  = inv ? ~b[W-1:0] : b[W-1:0];
      case (op)
        OP_SUB_W, OP_SUB_D: ci = 1'b1;
        OP_ADC_W, OP_ADC_D, OP_SBC_W, OP_SBC_D: ci = c[0];
        default: ci = 1'b0;
      endcase
      s = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};
      arith.n = s[W-1];
      arith.z = (s[W-1:0] == '0);
      arith.c = s[W];
      arith.v = (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]);
      logic_f.n = x[W-1];
      logic_f.z = (x == '0);
      logic_f.c = 1'b0;
      logic_f.v = 1'b0;
    end
  end

  always_comb begin
    case (op)
      OP_COPY:  flags = nzcv_t'(a[NZCV_LSB +: 4]);
      OP_ADD_W, OP_SUB_W, OP_ADC_W, OP_SBC_W: flags = g_w[0].arith;
      OP_ADD_D, OP_SUB_D, OP_ADC_D, OP_SBC_D: flags = g_w[1].arith;
      OP_LOG_W: flags = g_w[0].logic_f;
      OP_LOG_D: flags = g_w[1].logic_f;
      default:  flags = '0;
    endcase
  end
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit
  import lfu_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 32,
  parameter int NZCV_LSB = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [3:0]    rec_op,
  input  logic [DW-1:0] rec_a,
  input  logic [DW-1:0] rec_b,
  input  logic [DW-1:0] rec_c,
  input  logic [7:0]    query_sel,
  output logic [DW-1:0] flag_word,
  output logic [DW-1:0] cond_word
);
  logic [3:0]    st_op;
  logic [DW-1:0] st_a, st_b, st_c;
  nzcv_t         st_flags, q_flags;

  assign rec_ready = 1'b1;

  lfu_thunk_reg #(.DW(DW), .OPW(4)) u_thunk (
    .clk(clk), .rst_n(rst_n), .load(rec_valid & rec_ready),
    .op_in(rec_op), .a_in(rec_a), .b_in(rec_b), .c_in(rec_c),
    .op_q(st_op), .a_q(st_a), .b_q(st_b), .c_q(st_c)
  );

  lfu_flag_calc #(.DW(DW), .HW(HW), .NZCV_LSB(NZCV_LSB)) u_stored (
    .op(st_op), .a(st_a), .b(st_b), .c(st_c), .flags(st_flags)
  );

  lfu_flag_calc #(.DW(DW), .HW(HW), .NZCV_LSB(NZCV_LSB)) u_query (
    .op(query_sel[3:0]), .a(st_a), .b(st_b), .c(st_c), .flags(q_flags)
  );

  assign flag_word = {{(DW-4){1'b0}}, st_flags} << NZCV_LSB;
  assign cond_word = {{(DW-1){1'b0}}, cond_hit(query_sel[7:4], q_flags)};
endmodule

// File: rtl/lfu_checker.sv
module lfu_checker #(
  parameter int DW = 64,
  parameter int NZCV_LSB = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [3:0]    rec_op,
  input logic [DW-1:0] rec_a,
  input logic [7:0]    query_sel,
  input logic [DW-1:0] flag_word,
  input logic [DW-1:0] cond_word
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n) rec_ready);
  p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_op == 4'd0 |=> flag_word[NZCV_LSB +: 4] == $past(rec_a[NZCV_LSB +: 4]));
  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_op == 4'd9 || rec_op == 4'd10) |=> flag_word[NZCV_LSB +: 2] == 2'b00);
  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[DW-1:NZCV_LSB+4] == '0 && flag_word[NZCV_LSB-1:0] == '0);
  p_always_r11: assert property (@(posedge clk) disable iff (!rst_n)
    query_sel[7:5] == 3'b111 |-> cond_word[0]);
  p_cond_pad_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cond_word[DW-1:1] == '0);
  p_bad_op_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_op > 4'd10 |=> flag_word == '0);
  p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> $stable(flag_word));
endmodule

bind lazy_flag_unit lfu_checker #(.DW(DW), .NZCV_LSB(NZCV_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_op(rec_op), .rec_a(rec_a), .query_sel(query_sel),
  .flag_word(flag_word), .cond_word(cond_word)
);

// File: tb/sim_lazy_flag_unit.sv
module sim_lazy_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_valid = 1'b0;
  logic rec_ready;
  logic [3:0] rec_op = '0;
  logic [63:0] rec_a = '0, rec_b = '0, rec_c = '0;
  logic [7:0] query_sel = '0;
  logic [63:0] flag_word, cond_word;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lazy_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_op(rec_op), .rec_a(rec_a), .rec_b(rec_b), .rec_c(rec_c),
    .query_sel(query_sel), .flag_word(flag_word), .cond_word(cond_word)
  );

  function automatic logic [3:0] ref_nzcv(input logic [3:0] op, input logic [63:0] a, b, c);
    int w;
    logic signed [67:0] sa, sb, sr, smax, smin;
    logic [67:0] ua, ub, lim;
    logic [63:0] res, msk;
    logic n, z, cf, vf, bor;
    if (op == 0) return a[31:28];
    if (op > 10) return 4'h0;
    w = (op[0] == 1'b1) ? 32 : 64;
    msk = (w == 32) ? 64'hFFFF_FFFF : '1;
    ua = {4'b0, a & msk};
    ub = {4'b0, b & msk};
    sa = (w == 32) ? $signed({{36{a[31]}}, a[31:0]}) : $signed({{4{a[63]}}, a});
    sb = (w == 32) ? $signed({{36{b[31]}}, b[31:0]}) : $signed({{4{b[63]}}, b});
    smax = (68'sd1 <<< (w - 1)) - 68'sd1;
    smin = -(68'sd1 <<< (w - 1));
    lim = 68'd1 << w;
    cf = 0; vf = 0;
    if (op == 9 || op == 10) begin
      res = a & msk;
    end else if (op <= 2 || op == 5 || op == 6) begin
      bor = (op >= 5) ? c[0] : 1'b0;
      sr = sa + sb + (bor ? 68'sd1 : 68'sd0);
      cf = (ua + ub + {67'b0, bor}) >= lim;
      vf = (sr > smax) || (sr < smin);
      res = sr[63:0] & msk;
    end else begin
      bor = (op >= 7) ? ~c[0] : 1'b0;
      sr = sa - sb - (bor ? 68'sd1 : 68'sd0);
      cf = ua >= (ub + {67'b0, bor});
      vf = (sr > smax) || (sr < smin);
      res = sr[63:0] & msk;
    end
    n = (w == 32) ? res[31] : res[63];
    z = (res == 0);
    return {n, z, cf, vf};
  endfunction

  function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, cf, v;
    {n, z, cf, v} = f;
    case (cc)
      0: return z;        1: return !z;
      2: return cf;       3: return !cf;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cf && !z; 9: return !cf || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic put(input logic [3:0] op, input logic [63:0] a, b, c);
    @(negedge clk);
    rec_valid = 1'b1; rec_op = op; rec_a = a; rec_b = b; rec_c = c;
    @(posedge clk);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic put_chk(input string req, input logic [3:0] op, input logic [63:0] a, b, c);
    put(op, a, b, c);
    check(req, flag_word, {32'b0, ref_nzcv(op, a, b, c), 28'b0});
  endtask

  task automatic t_reset;
    check("R2 flags", flag_word, 64'h0);
    check("R1 ready", {63'b0, rec_ready}, 64'h1);
    query_sel = 8'h00; #1;
    check("R2 EQ after reset", cond_word, 64'h0);
  endtask

  task automatic t_copy;
    put_chk("R3 copy", 4'd0, 64'h0000_0000_A000_0000, 64'h5, 64'h7);
    check("R3 copy literal", flag_word, 64'h0000_0000_A000_0000);
  endtask

  task automatic t_add;
    put_chk("R4 add32 carry", 4'd1, 64'hFFFF_FFFF, 64'h1, 0);
    check("R4 add32 literal", flag_word, 64'h0000_0000_6000_0000);
    put_chk("R4 add32 ovf", 4'd1, 64'h7FFF_FFFF, 64'h1, 0);
    put_chk("R4 add64 ovf", 4'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0);
    put_chk("R4 add64 carry", 4'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
  endtask

  task automatic t_sub;
    put_chk("R5 sub32 equal", 4'd3, 64'h1234, 64'h1234, 0);
    check("R5 sub32 literal", flag_word, 64'h0000_0000_6000_0000);
    put_chk("R5 sub32 borrow", 4'd3, 64'h1, 64'h2, 0);
    put_chk("R5 sub64 ovf", 4'd4, 64'h8000_0000_0000_0000, 64'h1, 0);
    put_chk("R5 sub64 plain", 4'd4, 64'h10, 64'h3, 0);
  endtask

  task automatic t_carry;
    put_chk("R6 adc32 cin1", 4'd5, 64'hFFFF_FFFE, 64'h1, 64'h1);
    put_chk("R6 adc64 cin0", 4'd6, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'h0);
    put_chk("R6 sbc32 cin0", 4'd7, 64'h5, 64'h5, 64'h0);
    put_chk("R6 sbc64 cin1", 4'd8, 64'h5, 64'h5, 64'h1);
    put_chk("R6 sbc64 upper c ignored", 4'd8, 64'h5, 64'h5, 64'hFFFF_0000);
  endtask

  task automatic t_logic;
    put_chk("R7 log32 neg", 4'd9, 64'h8000_0000, 0, 0);
    put_chk("R7 log64 zero", 4'd10, 64'h0, 0, 0);
    check("R7 log64 literal", flag_word, 64'h0000_0000_4000_0000);
    put_chk("R7 log64 neg", 4'd10, 64'h8000_0000_0000_0001, 0, 0);
  endtask

  task automatic t_width32;
    put_chk("R8 log32 upper junk zero", 4'd9, 64'hDEAD_BEEF_0000_0000, 0, 0);
    put_chk("R8 add32 upper junk", 4'd1, 64'hFFFF_0000_0000_0001, 64'h1234_0000_0000_0001, 0);
    put_chk("R8 sub32 upper junk", 4'd3, 64'h0000_0001_0000_0000, 64'h0, 0);
  endtask

  task automatic t_conds;
    for (int f = 0; f < 16; f++) begin
      put(4'd0, {32'b0, f[3:0], 28'b0}, 0, 0);
      for (int cc = 0; cc < 16; cc++) begin
        query_sel = {cc[3:0], 4'd0}; #1;
        check(cc >= 14 ? "R11 always" : "R10 cond", cond_word, {63'b0, ref_cond(cc[3:0], f[3:0])});
      end
    end
  endtask

  task automatic t_query_op;
    put(4'd9, 64'h3, 64'h3, 0);
    query_sel = {4'd0, 4'd3}; #1;
    check("R12 query op sub gives EQ", cond_word, 64'h1);
    query_sel = {4'd2, 4'd9}; #1;
    check("R12 query op logic CS", cond_word, 64'h0);
    query_sel = {4'd1, 4'd4}; #1;
    check("R12 query op sub64 NE", cond_word, 64'h0);
  endtask

  task automatic t_bad_op;
    for (int op = 11; op < 16; op++)
      put_chk("R13 undefined op", op[3:0], 64'hF000_0000, 64'h0, 64'h1);
    check("R13 literal", flag_word, 64'h0);
  endtask

  task automatic t_hold;
    put(4'd0, 64'h9000_0000, 0, 0);
    @(negedge clk);
    rec_op = 4'd0; rec_a = 64'h6000_0000;
    repeat (3) @(negedge clk);
    check("R14 hold without valid", flag_word, 64'h0000_0000_9000_0000);
    check("R9 layout", flag_word & ~64'hF000_0000, 64'h0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_add();
    t_sub();
    t_carry();
    t_logic();
    t_width32();
    t_conds();
    t_query_op();
    t_bad_op();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule